// File: doc/BRIEF.md
# Triggered Channel Pulse Sequencer

This block drives the switch controls of one transmit channel. All channels share a trigger. When the trigger falls after a qualified high pulse, the channel counts its own programmed delay in fast-clock cycles. It then plays a stored pair of pattern words, one bit pair per tick of a divided clock. Each bit pair is decoded into one of four switch states: high side on, low side on, return-to-zero on, or every switch off (high impedance). When no sequence is running, the channel rests in return-to-zero.

The delay and divider codes use inverted encodings. A delay code of all ones disables the channel. A continuous-wave mode bypasses the pattern and makes the output alternate between the high and low switches. Invert swaps the high-side and low-side meanings of the two mixed bit pairs, which supports phase-inverted transmit. Enable low turns every switch off at once. The delay code, divider code, width and pattern words are captured on the cycle that a sequence starts.

Top module: `pulse_chan_seq`

## Requirements
- R1: Let edge F be the first rising clock edge that samples `trig_i` low after it was sampled high at two or more edges in a row. With delay code k (k not all ones), bit 0 of the pattern appears at the outputs after edge F + (1023 - k) + 3. Before that, the outputs show return-to-zero.
- R2: A delay code of 1111111111 never starts a sequence. In continuous-wave mode that code keeps all three outputs low.
- R3: A trigger that is sampled high at only one edge before going low starts nothing.
- R4: With divider code k, each bit pair is held for 64 - k clock cycles. Bits play from index 0 upward. Index i is taken from bit i of `pat_p_i` and bit i of `pat_n_i`.
- R5: With `wide_i` = 1 the sequence plays 32 bit pairs. With `wide_i` = 0 it plays 16 (indices 0 to 15). After the last pair the outputs return to return-to-zero and stay there until the next valid trigger.
- R6: With `inv_i` = 0, the pair P=1,N=0 drives `hi_on_o` only and P=0,N=1 drives `lo_on_o` only. With `inv_i` = 1 these two mappings swap.
- R7: The pair P=0,N=0 drives `rtz_on_o` only. The pair P=1,N=1 drives all three outputs low, whatever the value of `inv_i`.
- R8: With `cw_i` = 1, `en_i` = 1 and a delay code that is not all ones, exactly one of `hi_on_o` and `lo_on_o` is high at every cycle. The active one changes every 64 - k cycles, where k is the divider code.
- R9: While `en_i` is low, all three outputs are low in the same cycle. A running sequence is abandoned.
- R10: A trigger that falls while a sequence is counting its delay or playing has no effect. The running sequence completes unchanged, and no second sequence follows it.
- R11: At most one of the three outputs is high at any time.
- R12: While `rst_n` is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Shared trigger |
| en_i | input | 1 | Channel enable; low forces every switch off |
| inv_i | input | 1 | Swaps the high-side and low-side decodes |
| cw_i | input | 1 | Continuous-wave mode select |
| dly_code_i | input | 10 | Delay code; code k gives 1023 - k cycles, all ones disables the channel |
| div_code_i | input | 6 | Divider code; code k gives a divisor of 64 - k |
| wide_i | input | 1 | Pattern length: 1 selects 32 bits, 0 selects 16 bits |
| pat_p_i | input | 32 | P pattern word, bit 0 played first |
| pat_n_i | input | 32 | N pattern word, bit 0 played first |
| hi_on_o | output | 1 | High-side switch enable |
| lo_on_o | output | 1 | Low-side switch enable |
| rtz_on_o | output | 1 | Return-to-zero switch enable |

## Verification
A wrong internal state shows up within one bit period as a wrong switch state.

- A delay counter that is off by one moves the whole waveform by one cycle. The first mismatch therefore appears at the first bit boundary, where return-to-zero meets the first pattern bit.
- A wrong divider or a wrong bit index stretches, shortens or misorders the bit slots. This shows before the second slot ends.
- A bad end-of-pattern decision either cuts the waveform off or lets it run past the expected return-to-zero point.

The bench compares every cycle of each sequence against a computed waveform, so these errors surface on the cycle they occur. The same comparison catches a trigger that should have been ignored but restarted the channel.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_PLAY  = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic hi;
      logic lo;
      logic rtz;
   } sw_t;

   localparam sw_t SW_OFF = '{hi: 1'b0, lo: 1'b0, rtz: 1'b0};
   localparam sw_t SW_RTZ = '{hi: 1'b0, lo: 1'b0, rtz: 1'b1};
   localparam sw_t SW_HI  = '{hi: 1'b1, lo: 1'b0, rtz: 1'b0};
   localparam sw_t SW_LO  = '{hi: 1'b0, lo: 1'b1, rtz: 1'b0};

   // Map one P/N bit pair onto switch enables.
   function automatic sw_t pair_to_sw(input logic p, input logic n, input logic inv);
      sw_t s;
      if (!p && !n)        s = SW_RTZ;
      else if (p && n)     s = SW_OFF;
      else if (p ^ inv)    s = SW_HI;
      else                 s = SW_LO;
      return s;
   endfunction

endpackage

// File: rtl/pcs_trig_qual.sv
module pcs_trig_qual #(
   parameter int MIN_HIGH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic start_o
);
   localparam int CNT_W = $clog2(MIN_HIGH + 1);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_HIGH);

   generate
      if (MIN_HIGH < 1) begin : g_bad_min
         $error("pcs_trig_qual: MIN_HIGH must be at least 1");
      end
   endgenerate

   logic             trig_q;
   logic [CNT_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         hi_cnt <= '0;
      end else begin
         trig_q <= trig_i;
         if (!trig_q)
            hi_cnt <= '0;
         else if (hi_cnt != CNT_SAT)
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign start_o = !trig_q && (hi_cnt == CNT_SAT);

   a_r3_two_highs_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> ($past(trig_q) && $past(trig_q, 2)));

endmodule

// File: rtl/pcs_seq_core.sv
module pcs_seq_core
   import pcs_pkg::*;
#(
   parameter int DLY_W = 10,
   parameter int DIV_W = 6,
   parameter int PAT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en_i,
   input  logic             start_i,
   input  logic [DLY_W-1:0] dly_code_i,
   input  logic [DIV_W-1:0] div_code_i,
   input  logic             wide_i,
   input  logic [PAT_W-1:0] pat_p_i,
   input  logic [PAT_W-1:0] pat_n_i,
   output logic             play_o,
   output logic             bit_p_o,
   output logic             bit_n_o
);
   localparam int IDX_W = $clog2(PAT_W);
   localparam int DVC_W = DIV_W + 1;
   localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(PAT_W - 1);
   localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(PAT_W / 2 - 1);

   generate
      if (PAT_W < 4 || (PAT_W % 2) != 0) begin : g_bad_pat
         $error("pcs_seq_core: PAT_W must be even and at least 4");
      end
      if (DLY_W < 2 || DIV_W < 1) begin : g_bad_cnt
         $error("pcs_seq_core: counter widths too small");
      end
   endgenerate

   seq_state_e       st;
   logic [DLY_W-1:0] dly_cnt;
   logic [DVC_W-1:0] div_snap;
   logic [DVC_W-1:0] div_cnt;
   logic [IDX_W-1:0] bit_idx;
   logic             wide_snap;
   logic [PAT_W-1:0] p_snap;
   logic [PAT_W-1:0] n_snap;
   logic [DLY_W-1:0] dly_snap;

   logic             code_off;
   logic [IDX_W-1:0] last_idx;
   logic             slot_end;

   assign code_off = &dly_code_i;
   assign last_idx = wide_snap ? LAST_WIDE : LAST_NARROW;
   assign slot_end = (div_cnt == div_snap - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         dly_cnt   <= '0;
         div_snap  <= DVC_W'(1);
         div_cnt   <= '0;
         bit_idx   <= '0;
         wide_snap <= 1'b0;
         p_snap    <= '0;
         n_snap    <= '0;
         dly_snap  <= '0;
      end else if (!run_en_i) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start_i && !code_off) begin
                  st        <= ST_DELAY;
                  dly_cnt   <= ~dly_code_i;
                  dly_snap  <= dly_code_i;
                  div_snap  <= {1'b0, ~div_code_i} + DVC_W'(1);
                  wide_snap <= wide_i;
                  p_snap    <= pat_p_i;
                  n_snap    <= pat_n_i;
               end
            end
            ST_DELAY: begin
               if (dly_cnt == DLY_W'(1)) begin
                  st      <= ST_PLAY;
                  bit_idx <= '0;
                  div_cnt <= '0;
               end else begin
                  dly_cnt <= dly_cnt - 1'b1;
               end
            end
            ST_PLAY: begin
               if (slot_end) begin
                  div_cnt <= '0;
                  if (bit_idx == last_idx)
                     st <= ST_IDLE;
                  else
                     bit_idx <= bit_idx + 1'b1;
               end else begin
                  div_cnt <= div_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign play_o  = (st == ST_PLAY);
   assign bit_p_o = p_snap[bit_idx];
   assign bit_n_o = n_snap[bit_idx];

   a_r2_disabled_code_never_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DELAY) |-> !(&dly_snap));

   a_r1_play_only_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(play_o) |-> ($past(st) == ST_DELAY));

   a_r5_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      play_o |-> (bit_idx <= last_idx));

   a_r4_slot_counter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      play_o |-> (div_cnt < div_snap));

   a_r9_abort_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en_i |=> (st == ST_IDLE));

endmodule

// File: rtl/pcs_cw_gen.sv
module pcs_cw_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_code_i,
   output logic             phase_o
);
   localparam int DVC_W = DIV_W + 1;

   logic [DVC_W-1:0] cnt;
   logic [DVC_W-1:0] divisor;

   assign divisor = {1'b0, ~div_code_i} + DVC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         phase_o <= 1'b0;
      end else if (!run_i) begin
         cnt     <= '0;
         phase_o <= 1'b0;
      end else if (cnt >= divisor - 1'b1) begin
         cnt     <= '0;
         phase_o <= !phase_o;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r8_count_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && $stable(div_code_i)) |-> (cnt < divisor));

endmodule

// File: rtl/pcs_out_stage.sv
module pcs_out_stage
   import pcs_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  sw_t  d_i,
   output sw_t  q_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("pcs_out_stage: STAGES must be at least 1");
      end
   endgenerate

   sw_t pipe [STAGES+1];

   assign pipe[0] = d_i;

   for (genvar g = 0; g < STAGES; g++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[g+1] <= SW_OFF;
         else        pipe[g+1] <= pipe[g];
      end
   end

   assign q_o = pipe[STAGES];

   a_r11_stage_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_o));

endmodule

// File: rtl/pulse_chan_seq.sv
module pulse_chan_seq
   import pcs_pkg::*;
#(
   parameter int DLY_W      = 10,
   parameter int DIV_W      = 6,
   parameter int PAT_W      = 32,
   parameter int MIN_HIGH   = 2,
   parameter int OUT_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             en_i,
   input  logic             inv_i,
   input  logic             cw_i,
   input  logic [DLY_W-1:0] dly_code_i,
   input  logic [DIV_W-1:0] div_code_i,
   input  logic             wide_i,
   input  logic [PAT_W-1:0] pat_p_i,
   input  logic [PAT_W-1:0] pat_n_i,
   output logic             hi_on_o,
   output logic             lo_on_o,
   output logic             rtz_on_o
);
   logic start;
   logic seq_run;
   logic play;
   logic bit_p;
   logic bit_n;
   logic cw_phase;
   logic chan_off;
   sw_t  seq_sw;
   sw_t  cw_sw;
   sw_t  pre_sw;
   sw_t  out_sw;

   assign seq_run  = en_i && !cw_i;
   assign chan_off = &dly_code_i;

   pcs_trig_qual #(.MIN_HIGH(MIN_HIGH)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig_i),
      .start_o (start)
   );

   pcs_seq_core #(.DLY_W(DLY_W), .DIV_W(DIV_W), .PAT_W(PAT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en_i   (seq_run),
      .start_i    (start),
      .dly_code_i (dly_code_i),
      .div_code_i (div_code_i),
      .wide_i     (wide_i),
      .pat_p_i    (pat_p_i),
      .pat_n_i    (pat_n_i),
      .play_o     (play),
      .bit_p_o    (bit_p),
      .bit_n_o    (bit_n)
   );

   pcs_cw_gen #(.DIV_W(DIV_W)) u_cw (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (en_i && cw_i),
      .div_code_i (div_code_i),
      .phase_o    (cw_phase)
   );

   always_comb begin
      seq_sw = play ? pair_to_sw(bit_p, bit_n, inv_i) : SW_RTZ;
      if (chan_off)      cw_sw = SW_OFF;
      else if (cw_phase) cw_sw = SW_LO;
      else               cw_sw = SW_HI;
      pre_sw = cw_i ? cw_sw : seq_sw;
   end

   pcs_out_stage #(.STAGES(OUT_STAGES)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pre_sw),
      .q_o   (out_sw)
   );

   assign hi_on_o  = out_sw.hi  && en_i;
   assign lo_on_o  = out_sw.lo  && en_i;
   assign rtz_on_o = out_sw.rtz && en_i;

   a_r11_single_switch: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hi_on_o, lo_on_o, rtz_on_o}));

   a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> ({hi_on_o, lo_on_o, rtz_on_o} == 3'b000));

   a_r8_cw_one_side_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_i && en_i && $past(cw_i) && $past(en_i) && $past(cw_i, 2) && $past(en_i, 2)
       && !chan_off && $stable(dly_code_i) && ($past(dly_code_i, 2) == dly_code_i))
      |-> ((hi_on_o ^ lo_on_o) && !rtz_on_o));

endmodule

// File: tb/pulse_chan_seq_tb_top.sv
`timescale 1ns/1ps
module pulse_chan_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_i = 1'b0;
   logic        en_i = 1'b1;
   logic        inv_i = 1'b0;
   logic        cw_i = 1'b0;
   logic [9:0]  dly_code_i = 10'h3FF;
   logic [5:0]  div_code_i = 6'h3F;
   logic        wide_i = 1'b0;
   logic [31:0] pat_p_i = '0;
   logic [31:0] pat_n_i = '0;
   logic        hi_on_o, lo_on_o, rtz_on_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pulse_chan_seq dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .en_i(en_i), .inv_i(inv_i),
      .cw_i(cw_i), .dly_code_i(dly_code_i), .div_code_i(div_code_i), .wide_i(wide_i),
      .pat_p_i(pat_p_i), .pat_n_i(pat_n_i),
      .hi_on_o(hi_on_o), .lo_on_o(lo_on_o), .rtz_on_o(rtz_on_o)
   );

   function automatic logic [2:0] outs();
      return {hi_on_o, lo_on_o, rtz_on_o};
   endfunction

   // {hi,lo,rtz} for one bit pair
   function automatic logic [2:0] pair_exp(bit p, bit n, bit inv);
      if (!p && !n) return 3'b001;
      if (p && n)   return 3'b000;
      if (p ^ inv)  return 3'b100;
      return 3'b010;
   endfunction

   function automatic logic [2:0] wave_exp(int c, int d, int m, int w, bit inv,
                                           logic [31:0] p, logic [31:0] n);
      int s;
      if (d == 0) return 3'b001;
      s = c - (d + 3);
      if (s < 0 || s >= w * m) return 3'b001;
      return pair_exp(p[s / m], n[s / m], inv);
   endfunction

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_seq(input logic [9:0] dc, input logic [5:0] vc, input bit wd,
                          input bit iv, input logic [31:0] pp, input logic [31:0] nn,
                          input int retrig, input int endrop, input string tag);
      int d, m, w, last;
      bit bad;
      logic [2:0] exp, got;
      d = (dc == 10'h3FF) ? 0 : 1023 - int'(dc);
      m = 64 - int'(vc);
      w = wd ? 32 : 16;
      last = (d == 0) ? 100 : d + 3 + w * m + 20;
      bad = 1'b0;
      @(negedge clk);
      dly_code_i = dc; div_code_i = vc; wide_i = wd; inv_i = iv;
      pat_p_i = pp; pat_n_i = nn;
      trig_i = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      trig_i = 1'b0;
      for (int c = 0; c <= last; c++) begin
         @(posedge clk); @(negedge clk);
         exp = wave_exp(c, d, m, w, iv, pp, nn);
         if (endrop >= 0 && c > endrop) exp = 3'b000;
         got = outs();
         if (got !== exp && !bad) begin
            bad = 1'b1;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, c, got, exp);
         end
         if (c == retrig)     trig_i = 1'b1;
         if (c == retrig + 3) trig_i = 1'b0;
         if (c == endrop)     en_i = 1'b0;
      end
      checks++;
      if (bad) errors++;
      if (endrop >= 0) begin
         en_i = 1'b1;
         idle(5);
         check("R9 re-enable rests in rtz", outs(), 3'b001);
      end
   endtask

   task automatic cw_run(input logic [5:0] vc, input logic [9:0] dc, input string tag);
      int m, last_t, ntog;
      bit bad;
      logic [2:0] prev, cur;
      m = 64 - int'(vc);
      bad = 1'b0; ntog = 0; last_t = -1;
      @(negedge clk);
      div_code_i = vc; dly_code_i = dc; cw_i = 1'b1;
      idle(6);
      prev = outs();
      for (int c = 0; c < 6 * m + 4; c++) begin
         @(posedge clk); @(negedge clk);
         cur = outs();
         if (dc == 10'h3FF) begin
            if (cur !== 3'b000 && !bad) begin
               bad = 1'b1;
               $display("FAIL %s R2 actual=%b expected=000", tag, cur);
            end
         end else begin
            if (cur !== 3'b100 && cur !== 3'b010 && !bad) begin
               bad = 1'b1;
               $display("FAIL %s R8 R11 actual=%b expected=100 or 010", tag, cur);
            end
            if (cur !== prev) begin
               if (last_t >= 0 && (c - last_t) != m && !bad) begin
                  bad = 1'b1;
                  $display("FAIL %s R8 run length actual=%0d expected=%0d", tag, c - last_t, m);
               end
               last_t = c; ntog++;
            end
         end
         prev = cur;
      end
      if (dc != 10'h3FF && ntog < 3 && !bad) begin
         bad = 1'b1;
         $display("FAIL %s R8 toggles actual=%0d expected>=3", tag, ntog);
      end
      checks++;
      if (bad) errors++;
      cw_i = 1'b0;
      idle(5);
      check("R8 leaving cw rests in rtz", outs(), 3'b001);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rp, rn;
      int d, m;
      void'($urandom(32'd7351));
      idle(3);
      check("R12 outputs low in reset", outs(), 3'b000);
      rst_n = 1'b1;
      idle(4);
      check("R5 idle rests in rtz", outs(), 3'b001);

      // all four pair values, minimum delay, divide by one
      run_seq(10'h3FE, 6'h3F, 1'b0, 1'b0, 32'h0000_A5C3, 32'h0000_3C96, -1, -1, "R1 R4 R6 R7 min delay");
      run_seq(10'h3FE, 6'h3F, 1'b0, 1'b1, 32'h0000_A5C3, 32'h0000_3C96, -1, -1, "R6 R7 inverted");
      run_seq(10'h000, 6'h3F, 1'b0, 1'b0, 32'h0000_00F1, 32'h0000_0F02, -1, -1, "R1 max delay");
      run_seq(10'h3FD, 6'h00, 1'b0, 1'b0, 32'h0000_5A0F, 32'h0000_A0F0, -1, -1, "R4 divide by 64");
      run_seq(10'h3F0, 6'h3E, 1'b1, 1'b0, 32'h9F31_0000, 32'h60C2_FFFF, -1, -1, "R5 wide pattern");
      run_seq(10'h3F0, 6'h3E, 1'b0, 1'b0, 32'h9F31_0001, 32'h60C2_0000, -1, -1, "R5 narrow ignores upper half");
      run_seq(10'h3FF, 6'h3F, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, -1, -1, "R2 all-ones delay never fires");
      run_seq(10'h3F8, 6'h3D, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0000, 12, -1, "R10 retrigger ignored");
      run_seq(10'h3FA, 6'h3E, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, -1, 14, "R9 enable drop mid play");

      // single-edge trigger pulse
      @(negedge clk);
      dly_code_i = 10'h3FE; div_code_i = 6'h3F; pat_p_i = '1; pat_n_i = '0;
      trig_i = 1'b1;
      @(posedge clk); @(negedge clk);
      trig_i = 1'b0;
      begin
         bit bad = 1'b0;
         for (int c = 0; c < 60; c++) begin
            @(posedge clk); @(negedge clk);
            if (outs() !== 3'b001 && !bad) begin
               bad = 1'b1;
               $display("FAIL R3 short trigger actual=%b expected=001", outs());
            end
         end
         checks++;
         if (bad) errors++;
      end

      // trigger while disabled
      @(negedge clk);
      en_i = 1'b0;
      trig_i = 1'b1;
      idle(2);
      trig_i = 1'b0;
      begin
         bit bad = 1'b0;
         for (int c = 0; c < 40; c++) begin
            @(posedge clk); @(negedge clk);
            if (outs() !== 3'b000 && !bad) begin
               bad = 1'b1;
               $display("FAIL R9 disabled actual=%b expected=000", outs());
            end
         end
         checks++;
         if (bad) errors++;
      end
      en_i = 1'b1;
      idle(40);
      check("R9 no deferred start after enable", outs(), 3'b001);

      cw_run(6'h3D, 10'h3F0, "R8 cw divide by 3");
      cw_run(6'h3F, 10'h000, "R8 cw divide by 1");
      cw_run(6'h3A, 10'h3FF, "R2 cw disabled channel");

      for (int k = 0; k < 30; k++) begin
         d = 1 + int'($urandom % 60);
         m = 1 + int'($urandom % 5);
         rp = $urandom; rn = $urandom;
         run_seq(10'(1023 - d), 6'(64 - m), 1'($urandom), 1'($urandom), rp, rn,
                 -1, -1, "R1 R4 R5 R6 R7 R11 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule